// File: doc/BRIEF.md
# Debug Bus Match Comparator Channel

This block is one comparator channel of an on-chip debug unit for a small microcontroller bus. Each cycle it looks at the bus address, data, direction and valid strobe and compares them with a programmed address and data value. A control register sets how a hit is qualified and what the hit causes. A hit can request a state-sequencer transition straight away. In tag mode it instead marks the fetched opcode, and the request is raised only when that opcode reaches execution. A break setting ends the debug session on a hit, whatever the sequencer is doing.

The instruction queue is modelled by a simple interface. A fetch that matches in tag mode records the queue slot ID given on `busTagId`. A later execute strobe that carries the same ID releases the trigger, and a flush strobe discards the pending mark. The channel drives single-cycle registered pulses for trigger, breakpoint request, trace stop and disarm.

Top module: `dbg_match_chan`

## Requirements
- R1: When control bit 0 (enable) is clear, the channel raises no trigger, breakpoint, trace stop or disarm, and records no tag.
- R2: With control bit 1 (tag mode) clear, a qualified hit in bus cycle t gives a one-cycle `trigOut` pulse in cycle t+1.
- R3: A hit needs `busValid` high and `busAddr` equal to the address register (`regSel`=1). Outside tag mode, it also needs `busData` to agree with the data register (`regSel`=2, low DATA_W bits).
- R4: With control bit 3 (direction check) clear, read and write cycles both hit. With it set, control bit 4 = 0 hits only writes (`busRead`=0) and = 1 hits only reads (`busRead`=1).
- R5: With control bit 5 (inverted data) set, the data term is true when `busData` differs from the data register. It applies only when parameter HAS_INV_DATA is 1.
- R6: In tag mode, bits 3, 4 and 5 and the data value are ignored. An address hit records `busTagId`. `trigOut` pulses one cycle after an `execValid` whose `execTagId` equals the recorded ID, and the mark is then consumed.
- R7: A `flushReq` drops any pending mark, so a later execute of that ID gives no trigger. An execute of a different ID gives no trigger either.
- R8: With control bit 2 (break) set, a trigger event also pulses `traceStop` and `disarmOut` and clears `armed`. After that, nothing fires until `armReq` is raised again.
- R9: On a break event, `brkReq` pulses only if `brkEnable` is high. Otherwise the session still ends without it.
- R10: A control write (`regSel`=0) takes effect from the next bus cycle. A hit in the same cycle as the write uses the old settings.
- R11: `armed` is low after reset and is set by `armReq`. Outputs fire only while `armed` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 address, 2 data |
| regWdata | input | ADDR_W | Register write value |
| armReq | input | 1 | Arms the channel |
| brkEnable | input | 1 | Global breakpoint enable |
| busValid | input | 1 | Bus cycle valid |
| busAddr | input | ADDR_W | Bus address |
| busData | input | DATA_W | Bus data |
| busRead | input | 1 | 1 for read, 0 for write |
| busTagId | input | TAG_W | Queue slot of a fetched opcode |
| execValid | input | 1 | An opcode reaches execution |
| execTagId | input | TAG_W | Queue slot of the executing opcode |
| flushReq | input | 1 | Queue flush |
| trigOut | output | 1 | Sequencer transition request pulse |
| brkReq | output | 1 | Breakpoint request pulse |
| traceStop | output | 1 | Trace termination pulse |
| disarmOut | output | 1 | Disarm pulse |
| armed | output | 1 | Channel armed state |

## Verification
The deferred trigger is the hardest case to reach from the ports. It needs a tag-mode hit, followed in a later cycle by an execute strobe whose ID matches. The stimulus first captures a mark with deliberately non-matching direction and data, which shows those fields are ignored. It then plays an execute with a different ID and then one with the right ID, and finally replays the right ID to show the mark was consumed. A separate sequence flushes before executing, and another writes the control register in the same cycle as a hit to expose the write timing.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int CTL_W    = 6;
  localparam int B_EN     = 0;
  localparam int B_TAG    = 1;
  localparam int B_BRK    = 2;
  localparam int B_DIREN  = 3;
  localparam int B_DIRRD  = 4;
  localparam int B_INV    = 5;
  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  typedef struct packed {
    logic ldAddr;
    logic ldData;
    logic tagMode;
    logic dirEn;
    logic dirRead;
    logic invData;
  } cmpStrobe_t;
endpackage

// File: rtl/dbgm_dpath.sv
module dbgm_dpath
  import dbgm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter bit HAS_INV_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpStrobe_t        stb,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRead,
  output logic              busHit
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic addrEq, dataEq, dataOk, dirOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (stb.ldAddr) addrQ <= regWdata;
      if (stb.ldData) dataQ <= regWdata[DATA_W-1:0];
    end
  end

  assign addrEq = (busAddr == addrQ);
  assign dataEq = (busData == dataQ);

  generate
    if (HAS_INV_DATA) begin : g_inv
      assign dataOk = dataEq ^ stb.invData;
    end else begin : g_noinv
      assign dataOk = dataEq;
    end
  endgenerate

  assign dirOk  = !stb.dirEn || (busRead == stb.dirRead);
  assign busHit = busValid && addrEq && (stb.tagMode || (dataOk && dirOk));

  // R4: outside tag mode a direction-checked hit follows the selected direction
  a_r4_dir_respected: assert property (@(posedge clk) disable iff (!rstN)
    (busHit && !stb.tagMode && stb.dirEn) |-> (busRead == stb.dirRead));
  // R3: no hit on an invalid cycle or a foreign address
  a_r3_needs_addr: assert property (@(posedge clk) disable iff (!rstN)
    busHit |-> (busValid && busAddr == addrQ));
endmodule

// File: rtl/dbgm_ctrl.sv
module dbgm_ctrl
  import dbgm_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [CTL_W-1:0] ctlWdata,
  input  logic             armReq,
  input  logic             brkEnable,
  input  logic             busHit,
  input  logic [TAG_W-1:0] busTagId,
  input  logic             execValid,
  input  logic [TAG_W-1:0] execTagId,
  input  logic             flushReq,
  output cmpStrobe_t       stb,
  output logic             trigOut,
  output logic             brkReq,
  output logic             traceStop,
  output logic             disarmOut,
  output logic             armed
);
  logic [CTL_W-1:0] ctlQ;
  logic             pendQ;
  logic [TAG_W-1:0] pendIdQ;
  logic en, tagMode, brkSel;
  logic immHit, tagCap, execHit, trigEvt, brkEvt;

  assign en      = ctlQ[B_EN];
  assign tagMode = ctlQ[B_TAG];
  assign brkSel  = ctlQ[B_BRK];

  always_comb begin
    stb.ldAddr  = regWe && (regSel == SEL_ADDR);
    stb.ldData  = regWe && (regSel == SEL_DATA);
    stb.tagMode = tagMode;
    stb.dirEn   = ctlQ[B_DIREN];
    stb.dirRead = ctlQ[B_DIRRD];
    stb.invData = ctlQ[B_INV];
  end

  assign immHit  = en && busHit && !tagMode;
  assign tagCap  = en && busHit && tagMode && armed && !flushReq;
  assign execHit = en && tagMode && pendQ && execValid && !flushReq
                   && (execTagId == pendIdQ);
  assign trigEvt = armed && (immHit || execHit);
  assign brkEvt  = trigEvt && brkSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ      <= '0;
      pendQ     <= 1'b0;
      pendIdQ   <= '0;
      trigOut   <= 1'b0;
      brkReq    <= 1'b0;
      traceStop <= 1'b0;
      disarmOut <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (regWe && regSel == SEL_CTL) ctlQ <= ctlWdata;
      trigOut   <= trigEvt;
      brkReq    <= brkEvt && brkEnable;
      traceStop <= brkEvt;
      disarmOut <= brkEvt;
      if (brkEvt)      armed <= 1'b0;
      else if (armReq) armed <= 1'b1;
      if (!en || flushReq || brkEvt || !armed) begin
        pendQ <= 1'b0;
      end else if (tagCap) begin
        pendQ   <= 1'b1;
        pendIdQ <= busTagId;
      end else if (execHit) begin
        pendQ <= 1'b0;
      end
    end
  end

  a_r1_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!trigOut && !brkReq && !traceStop && !pendQ));
  a_r9_brk_gated: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> ($past(brkEnable) && traceStop));
  a_r8_stop_disarms: assert property (@(posedge clk) disable iff (!rstN)
    traceStop |-> (!armed && disarmOut));
  a_r11_only_armed: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> $past(armed));
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !pendQ);
endmodule

// File: rtl/dbg_match_chan.sv
module dbg_match_chan
  import dbgm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3,
  parameter bit HAS_INV_DATA = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              armReq,
  input  logic              brkEnable,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRead,
  input  logic [TAG_W-1:0]  busTagId,
  input  logic              execValid,
  input  logic [TAG_W-1:0]  execTagId,
  input  logic              flushReq,
  output logic              trigOut,
  output logic              brkReq,
  output logic              traceStop,
  output logic              disarmOut,
  output logic              armed
);
  cmpStrobe_t stb;
  logic busHit;

  dbgm_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_INV_DATA(HAS_INV_DATA)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata),
    .busValid(busValid), .busAddr(busAddr), .busData(busData),
    .busRead(busRead), .busHit(busHit)
  );

  dbgm_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .ctlWdata(regWdata[CTL_W-1:0]), .armReq(armReq), .brkEnable(brkEnable),
    .busHit(busHit), .busTagId(busTagId), .execValid(execValid),
    .execTagId(execTagId), .flushReq(flushReq), .stb(stb),
    .trigOut(trigOut), .brkReq(brkReq), .traceStop(traceStop),
    .disarmOut(disarmOut), .armed(armed)
  );
endmodule

// File: tb/sim_dbg_match_chan.sv
`timescale 1ns/1ps
module sim_dbg_match_chan;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 0; logic [1:0] regSel = 0; logic [15:0] regWdata = 0;
  logic armReq = 0, brkEnable = 0, busValid = 0, busRead = 0;
  logic [15:0] busAddr = 0; logic [7:0] busData = 0;
  logic [2:0] busTagId = 0, execTagId = 0;
  logic execValid = 0, flushReq = 0;
  logic trigOut, brkReq, traceStop, disarmOut, armed;
  int nChk = 0, nBad = 0, cyc = 0;
  logic sTrig, sBrk, sStop, sDis;

  localparam logic [15:0] A = 16'h1234;
  localparam logic [7:0]  D = 8'h5A;

  always #2 clk = ~clk;

  dbg_match_chan u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic sampleOut;
    sTrig = trigOut; sBrk = brkReq; sStop = traceStop; sDis = disarmOut;
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk); regWe = 1; regSel = sel; regWdata = val;
    @(negedge clk); regWe = 0;
  endtask

  task automatic doArm;
    @(negedge clk); armReq = 1;
    @(negedge clk); armReq = 0;
  endtask

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rd,
                     input logic v = 1'b1, input logic [2:0] id = 3'd0);
    @(negedge clk); busValid = v; busAddr = a; busData = d; busRead = rd; busTagId = id;
    @(negedge clk); sampleOut(); busValid = 0;
  endtask

  task automatic exec(input logic [2:0] id);
    @(negedge clk); execValid = 1; execTagId = id;
    @(negedge clk); sampleOut(); execValid = 0;
  endtask

  task automatic t_reset;
    chk("R11 reset armed", armed, 0);
    chk("R11 reset trig", trigOut, 0);
    chk("R8 reset stop", traceStop, 0);
  endtask

  task automatic t_unarmed;
    wrReg(2'd1, A); wrReg(2'd2, {8'h0, D}); wrReg(2'd0, 16'h0001);
    bus(A, D, 1); chk("R11 unarmed no trig", sTrig, 0);
    doArm(); chk("R11 armReq sets armed", armed, 1);
  endtask

  task automatic t_enable;
    wrReg(2'd0, 16'h0000);
    bus(A, D, 1); chk("R1 disabled no trig", sTrig, 0);
  endtask

  task automatic t_imm;
    wrReg(2'd0, 16'h0001);
    bus(A, D, 1); chk("R2 hit trig", sTrig, 1);
    @(negedge clk); chk("R2 single pulse", trigOut, 0);
    bus(A + 16'd1, D, 1); chk("R3 wrong addr", sTrig, 0);
    bus(A, D ^ 8'h01, 1); chk("R3 wrong data", sTrig, 0);
    bus(A, D, 1, 1'b0); chk("R3 invalid cycle", sTrig, 0);
  endtask

  task automatic t_dir;
    bus(A, D, 0); chk("R4 no dir check write", sTrig, 1);
    wrReg(2'd0, 16'h0009);
    bus(A, D, 0); chk("R4 write sel write", sTrig, 1);
    bus(A, D, 1); chk("R4 write sel read", sTrig, 0);
    wrReg(2'd0, 16'h0019);
    bus(A, D, 1); chk("R4 read sel read", sTrig, 1);
    bus(A, D, 0); chk("R4 read sel write", sTrig, 0);
  endtask

  task automatic t_inv;
    wrReg(2'd0, 16'h0021);
    bus(A, D, 0); chk("R5 inv equal", sTrig, 0);
    bus(A, 8'h33, 0); chk("R5 inv differ", sTrig, 1);
  endtask

  task automatic t_tag;
    wrReg(2'd0, 16'h003B);
    bus(A, D, 0, 1'b1, 3'd5); chk("R6 tag no immediate trig", sTrig, 0);
    exec(3'd2); chk("R7 other id no trig", sTrig, 0);
    exec(3'd5); chk("R6 exec tagged trig", sTrig, 1);
    exec(3'd5); chk("R6 mark consumed", sTrig, 0);
  endtask

  task automatic t_flush;
    bus(A, 8'h00, 1, 1'b1, 3'd4);
    @(negedge clk); flushReq = 1;
    @(negedge clk); flushReq = 0;
    exec(3'd4); chk("R7 flushed no trig", sTrig, 0);
  endtask

  task automatic t_wrtiming;
    wrReg(2'd0, 16'h0001);
    @(negedge clk); regWe = 1; regSel = 2'd0; regWdata = 16'h0000;
    busValid = 1; busAddr = A; busData = D; busRead = 1;
    @(negedge clk); sampleOut(); regWe = 0; busValid = 0;
    chk("R10 same cycle old setting", sTrig, 1);
    bus(A, D, 1); chk("R10 new setting applied", sTrig, 0);
  endtask

  task automatic t_break;
    wrReg(2'd0, 16'h0005); brkEnable = 0;
    bus(A, D, 1);
    chk("R8 break trig", sTrig, 1);
    chk("R8 trace stop", sStop, 1);
    chk("R8 disarm pulse", sDis, 1);
    chk("R9 no brk without enable", sBrk, 0);
    chk("R8 armed cleared", armed, 0);
    bus(A, D, 1); chk("R8 silent after disarm", sTrig, 0);
    doArm(); brkEnable = 1;
    bus(A, D, 1);
    chk("R9 brk with enable", sBrk, 1);
    chk("R8 stop again", sStop, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        nChk++; nBad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset(); t_unarmed(); t_enable(); t_imm(); t_dir(); t_inv();
    t_tag(); t_flush(); t_wrtiming(); t_break();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule